// File: doc/BRIEF.md
# Packed Single-Precision Fused Multiply-Add Unit

This block computes one fused multiply-add per 32-bit lane of a 128-bit packed operand set. Each lane forms the exact product of two single-precision values, adds or subtracts a third value, and rounds the sum once to the nearest representable value, with ties going to even. The product is never rounded before the addition.

Three register operands enter each cycle, and a strobe marks them valid. A 2-bit order select decides which operand is multiplier, multiplicand and addend. Operand `src_a` is the destination register. A 3-bit operation select picks the sign treatment: plain, subtracted addend, negated product, both, or an addend sign that alternates by lane parity. In scalar mode only lane 0 is computed, and the upper lanes of the result carry `src_a` unchanged. The result and a valid flag are registered one cycle after the strobe.

Inputs whose exponent field is zero are taken as signed zero. Results below the normal range are flushed to signed zero.

Top module: `fma_packed_unit`

## Requirements
- R1: Each lane returns round(x·y ± z) with the exact product and a single rounding, ties to even; lane i occupies bits [32i+31:32i].
- R2: The order select picks the operands. Code 0 gives x=a, y=c, z=b. Code 1 gives x=b, y=a, z=c. Code 2 gives x=b, y=c, z=a. Code 3 behaves as code 1.
- R3: The operation select picks the sign variant. Code 0 gives +x·y+z and code 1 gives +x·y−z. Code 2 gives −x·y+z and code 3 gives −x·y−z. Codes 6 and 7 behave as code 0.
- R4: Code 4 subtracts the addend in even lanes and adds it in odd lanes. Code 5 adds it in even lanes and subtracts it in odd lanes.
- R5: When `scalar_mode` is 1, lane 0 is computed and result lanes 1 to 3 equal the matching lanes of `src_a`.
- R6: The following zero rules apply:
  - An input with exponent field 0 counts as a zero of its sign.
  - An exact zero sum of two nonzero terms of opposite sign gives +0.
  - A sum of two zero terms is −0 only when both are negative.
  - A rounded result below 2^-126 becomes a zero with the result's sign.
- R7: Any NaN input gives 0x7FC00000. So do infinity times zero, and infinite product and addend of opposite effective sign. Otherwise an infinite term gives an infinity of its effective sign. A rounded result of 2^128 or more gives an infinity of the result's sign.
- R8: `out_valid` is 1 in the cycle after `in_valid` was 1 and 0 otherwise. `result` updates only after a strobe and holds its value when there is none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operands valid strobe |
| src_a | input | 128 | Destination register operand, four lanes |
| src_b | input | 128 | Second operand, four lanes |
| src_c | input | 128 | Third operand, four lanes |
| order_sel | input | 2 | Operand order select |
| op_sel | input | 3 | Sign variant select |
| scalar_mode | input | 1 | 1 = lane 0 only, upper lanes from src_a |
| out_valid | output | 1 | Result valid, one cycle after strobe |
| result | output | 128 | Rounded results, four lanes |

## Verification
The bench builds the unit with its default of four lanes. Four lanes put both even and odd lanes in reach, so the alternating add/subtract codes are checked in both directions. Four lanes also give three upper lanes whose scalar pass-through can be observed. Random vectors keep the addend within a few binades of the product, so that a double-precision reference computes the sum exactly before the single rounding step. Directed vectors cover:
- ties
- products whose low bits survive cancellation
- signed zeros
- infinities and NaN
- overflow
- flush of tiny results

// File: rtl/fma_pkg.sv
package fma_pkg;
    localparam int FP_W    = 32;
    localparam int EXP_W   = 8;
    localparam int MAN_W   = 23;
    localparam int SIG_W   = MAN_W + 1;
    localparam int PROD_W  = 2 * SIG_W;
    localparam int WIN_W   = PROD_W + 26;
    localparam int SUM_W   = WIN_W + 1;
    localparam int BIAS    = 127;
    localparam logic [FP_W-1:0] QNAN = 32'h7FC0_0000;

    typedef enum logic [2:0] {
        OP_MADD   = 3'd0,
        OP_MSUB   = 3'd1,
        OP_NMADD  = 3'd2,
        OP_NMSUB  = 3'd3,
        OP_ADDSUB = 3'd4,
        OP_SUBADD = 3'd5,
        OP_RSV6   = 3'd6,
        OP_RSV7   = 3'd7
    } fma_op_e;

    typedef enum logic [1:0] {
        ORD_ACB = 2'd0,
        ORD_BAC = 2'd1,
        ORD_BCA = 2'd2,
        ORD_RSV = 2'd3
    } fma_ord_e;
endpackage

// File: rtl/fma_operand_sel.sv
module fma_operand_sel
    import fma_pkg::*;
(
    input  logic [1:0]      order_sel,
    input  logic [FP_W-1:0] a,
    input  logic [FP_W-1:0] b,
    input  logic [FP_W-1:0] c,
    output logic [FP_W-1:0] x,
    output logic [FP_W-1:0] y,
    output logic [FP_W-1:0] z
);
    always_comb begin
        case (fma_ord_e'(order_sel))
            ORD_ACB: begin x = a; y = c; z = b; end
            ORD_BCA: begin x = b; y = c; z = a; end
            default: begin x = b; y = a; z = c; end
        endcase
    end
endmodule

// File: rtl/fma_sign_ctrl.sv
module fma_sign_ctrl
    import fma_pkg::*;
#(
    parameter int LANE_IDX = 0
) (
    input  logic [2:0] op_sel,
    output logic       neg_prod,
    output logic       sub_add
);
    localparam logic EVEN_LANE = ((LANE_IDX % 2) == 0);

    always_comb begin
        neg_prod = 1'b0;
        sub_add  = 1'b0;
        case (fma_op_e'(op_sel))
            OP_MSUB:   sub_add = 1'b1;
            OP_NMADD:  neg_prod = 1'b1;
            OP_NMSUB:  begin neg_prod = 1'b1; sub_add = 1'b1; end
            OP_ADDSUB: sub_add = EVEN_LANE;
            OP_SUBADD: sub_add = !EVEN_LANE;
            default:   ;
        endcase
    end
endmodule

// File: rtl/fma_lane.sv
module fma_lane
    import fma_pkg::*;
(
    input  logic [FP_W-1:0] x,
    input  logic [FP_W-1:0] y,
    input  logic [FP_W-1:0] z,
    input  logic            neg_prod,
    input  logic            sub_add,
    output logic [FP_W-1:0] res
);
    function automatic logic [WIN_W-1:0] shr_jam(logic [WIN_W-1:0] v, logic [10:0] amt);
        logic [WIN_W-1:0] lost;
        if (amt >= 11'(WIN_W)) return {{(WIN_W-1){1'b0}}, |v};
        lost = v & ~({WIN_W{1'b1}} << amt[6:0]);
        return (v >> amt[6:0]) | {{(WIN_W-1){1'b0}}, |lost};
    endfunction

    logic [EXP_W-1:0] ex, ey, ez;
    logic [MAN_W-1:0] fx, fy, fz;
    logic             sp, sc, p_zero, c_zero, p_inf, c_inf, any_nan;
    logic [PROD_W-1:0] prod;
    logic signed [10:0] pe, ce, d, big_e, re, re_f;
    logic [10:0]       amt;
    logic [WIN_W-1:0]  pw, cw, pa, ca;
    logic [SUM_W-1:0]  sum, norm;
    logic              rs, up;
    logic [6:0]        lz;
    logic [MAN_W:0]    mrnd;

    assign {ex, fx} = x[FP_W-2:0];
    assign {ey, fy} = y[FP_W-2:0];
    assign {ez, fz} = z[FP_W-2:0];
    assign sp      = x[FP_W-1] ^ y[FP_W-1] ^ neg_prod;
    assign sc      = z[FP_W-1] ^ sub_add;
    assign p_zero  = (ex == '0) || (ey == '0);
    assign c_zero  = (ez == '0);
    assign p_inf   = (ex == '1 && fx == '0) || (ey == '1 && fy == '0);
    assign c_inf   = (ez == '1 && fz == '0);
    assign any_nan = (ex == '1 && fx != '0) || (ey == '1 && fy != '0) || (ez == '1 && fz != '0);
    assign prod    = PROD_W'({1'b1, fx}) * PROD_W'({1'b1, fy});
    assign pe      = $signed({3'b000, ex}) + $signed({3'b000, ey}) - 11'sd127;
    assign ce      = $signed({3'b000, ez});

    always_comb begin
        pw = p_zero ? '0 : {prod, 26'd0};
        cw = c_zero ? '0 : {2'b01, fz, 49'd0};
        d  = pe - ce;
        amt = d[10] ? 11'(-d) : 11'(d);
        // Align the smaller term to the larger one, jamming lost bits into bit 0.
        if (p_zero) begin
            big_e = ce; pa = pw; ca = cw;
        end else if (c_zero) begin
            big_e = pe; pa = pw; ca = cw;
        end else if (!d[10]) begin
            big_e = pe; pa = pw; ca = shr_jam(cw, amt);
        end else begin
            big_e = ce; pa = shr_jam(pw, amt); ca = cw;
        end
        if (sp == sc) begin
            sum = {1'b0, pa} + {1'b0, ca}; rs = sp;
        end else if (pa >= ca) begin
            sum = {1'b0, pa - ca}; rs = sp;
        end else begin
            sum = {1'b0, ca - pa}; rs = sc;
        end
        lz = 7'(SUM_W);
        for (int i = 0; i < SUM_W; i++) begin
            if (sum[i]) lz = 7'(SUM_W - 1 - i);
        end
        norm = sum << lz;
        re   = big_e + 11'sd2 - $signed({4'b0000, lz});
        up   = norm[50] & ((|norm[49:0]) | norm[51]);
        mrnd = {1'b0, norm[73:51]} + {{MAN_W{1'b0}}, up};
        re_f = re + $signed({10'd0, mrnd[MAN_W]});

        if (any_nan || (p_inf && p_zero) || (p_inf && c_inf && sp != sc)) begin
            res = QNAN;
        end else if (p_inf) begin
            res = {sp, 8'hFF, 23'd0};
        end else if (c_inf) begin
            res = {sc, 8'hFF, 23'd0};
        end else if (!norm[SUM_W-1]) begin
            res = {(p_zero && c_zero) ? (sp & sc) : 1'b0, 31'd0};
        end else if (re_f >= 11'sd255) begin
            res = {rs, 8'hFF, 23'd0};
        end else if (re_f <= 11'sd0) begin
            res = {rs, 31'd0};
        end else begin
            res = {rs, re_f[7:0], mrnd[MAN_W-1:0]};
        end
    end

    // R7: a NaN on any operand must reach the lane output as the default NaN
    always_comb begin
        if (any_nan) begin
            a_nan_in_r7: assert (res == QNAN);
        end
    end
endmodule

// File: rtl/fma_packed_unit.sv
module fma_packed_unit
    import fma_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic [LANES*FP_W-1:0]   src_a,
    input  logic [LANES*FP_W-1:0]   src_b,
    input  logic [LANES*FP_W-1:0]   src_c,
    input  logic [1:0]              order_sel,
    input  logic [2:0]              op_sel,
    input  logic                    scalar_mode,
    output logic                    out_valid,
    output logic [LANES*FP_W-1:0]   result
);
    localparam int DATA_W = LANES * FP_W;

    typedef struct packed {
        logic              vld;
        logic [DATA_W-1:0] res;
    } unit_state_t;

    unit_state_t st_d, st_q;
    logic [DATA_W-1:0] lane_res;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [FP_W-1:0] x, y, z;
        logic            neg_prod, sub_add;

        fma_operand_sel u_sel (
            .order_sel (order_sel),
            .a         (src_a[l*FP_W +: FP_W]),
            .b         (src_b[l*FP_W +: FP_W]),
            .c         (src_c[l*FP_W +: FP_W]),
            .x         (x),
            .y         (y),
            .z         (z)
        );

        fma_sign_ctrl #(.LANE_IDX(l)) u_sign (
            .op_sel   (op_sel),
            .neg_prod (neg_prod),
            .sub_add  (sub_add)
        );

        fma_lane u_lane (
            .x        (x),
            .y        (y),
            .z        (z),
            .neg_prod (neg_prod),
            .sub_add  (sub_add),
            .res      (lane_res[l*FP_W +: FP_W])
        );
    end

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            for (int l = 0; l < LANES; l++) begin
                st_d.res[l*FP_W +: FP_W] = (scalar_mode && l != 0) ?
                    src_a[l*FP_W +: FP_W] : lane_res[l*FP_W +: FP_W];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.vld;
    assign result    = st_q.res;

    p_valid_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_no_spurious_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(result));

    if (LANES > 1) begin : g_scalar_chk
        p_scalar_pass_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && scalar_mode) |=>
                (result[DATA_W-1:FP_W] == $past(src_a[DATA_W-1:FP_W])));
    end
endmodule

// File: tb/fma_packed_unit_tb.sv
module fma_packed_unit_tb;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [127:0] src_a = '0, src_b = '0, src_c = '0;
    logic [1:0]   order_sel = '0;
    logic [2:0]   op_sel = '0;
    logic         scalar_mode = 1'b0;
    logic         out_valid;
    logic [127:0] result;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    fma_packed_unit u_dut (
        .clk (clk), .rst_n (rst_n), .in_valid (in_valid),
        .src_a (src_a), .src_b (src_b), .src_c (src_c),
        .order_sel (order_sel), .op_sel (op_sel), .scalar_mode (scalar_mode),
        .out_valid (out_valid), .result (result)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic real pow2(int k);
        real v = 1.0;
        if (k >= 0) for (int i = 0; i < k; i++) v = v * 2.0;
        else        for (int i = 0; i < -k; i++) v = v / 2.0;
        return v;
    endfunction

    function automatic real mag(logic [31:0] f);
        return real'({1'b1, f[22:0]}) * pow2(int'(f[30:23]) - 150);
    endfunction

    function automatic logic [31:0] to_f32(real r);
        logic [63:0] db = $realtobits(r);
        int fe = int'(db[62:52]) - 1023 + 127;
        logic [23:0] m = {1'b0, db[51:29]};
        bit up = db[28] && ((|db[27:0]) || db[29]);
        m = m + 24'(up);
        if (m[23]) fe++;
        if (fe >= 255) return {db[63], 8'hFF, 23'd0};
        if (fe <= 0)   return {db[63], 31'd0};
        return {db[63], 8'(fe), m[22:0]};
    endfunction

    // Reference: exact sum in double precision (inputs constrained), then one rounding to single.
    function automatic logic [31:0] ref_fma(logic [31:0] x, logic [31:0] y, logic [31:0] z, bit neg, bit sub);
        bit sp = x[31] ^ y[31] ^ neg;
        bit sc = z[31] ^ sub;
        bit xz = x[30:23] == 0, yz = y[30:23] == 0, cz = z[30:23] == 0;
        bit xi = x[30:23] == 8'hFF && x[22:0] == 0, yi = y[30:23] == 8'hFF && y[22:0] == 0;
        bit ci = z[30:23] == 8'hFF && z[22:0] == 0;
        bit nan = (x[30:23] == 8'hFF && x[22:0] != 0) || (y[30:23] == 8'hFF && y[22:0] != 0) ||
                  (z[30:23] == 8'hFF && z[22:0] != 0);
        bit pz = xz || yz, pi = xi || yi;
        real pv, cv, r;
        if (nan || (pi && pz) || (pi && ci && sp != sc)) return 32'h7FC00000;
        if (pi) return {sp, 8'hFF, 23'd0};
        if (ci) return {sc, 8'hFF, 23'd0};
        pv = pz ? 0.0 : mag(x) * mag(y);
        cv = cz ? 0.0 : mag(z);
        r  = (sp ? -pv : pv) + (sc ? -cv : cv);
        if (r == 0.0) return {(pz && cz) ? (sp & sc) : 1'b0, 31'd0};
        return to_f32(r);
    endfunction

    task automatic apply(logic [127:0] a, logic [127:0] b, logic [127:0] c,
                         logic [1:0] ord, logic [2:0] op, logic sc);
        @(negedge clk);
        src_a = a; src_b = b; src_c = c;
        order_sel = ord; op_sel = op; scalar_mode = sc; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // Same x,y,z in every lane with order code 1 (x=b, y=a, z=c), op 0, packed.
    task automatic directed(string req, logic [31:0] x, logic [31:0] y, logic [31:0] z, logic [31:0] exp);
        apply({4{y}}, {4{x}}, {4{z}}, 2'd1, 3'd0, 1'b0);
        for (int l = 0; l < 4; l++) chk(req, result[l*32 +: 32], exp);
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            checks++; failures++;
            $display("FAIL R8 watchdog actual=hang expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [127:0] a, b, c, exp_v;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        chk("R8 reset valid", {31'd0, out_valid}, 32'd0);
        chk("R8 reset result", result[31:0], 32'd0);
        rst_n = 1'b1;

        // R1: single rounding
        directed("R1 tie to even down", 32'h3F800000, 32'h3F800000, 32'h33800000, 32'h3F800000);
        directed("R1 tie to even up",   32'h3F800000, 32'h3F800000, 32'h34400000, 32'h3F800002);
        directed("R1 unrounded product", 32'h3F800001, 32'h3F800001, 32'hBF800002, 32'h28800000);
        // R6: zeros and flush
        directed("R6 cancel to +0",    32'h40000000, 32'h40400000, 32'hC0C00000, 32'h00000000);
        directed("R6 -0 plus -0",      32'h80000000, 32'h3F800000, 32'h80000000, 32'h80000000);
        directed("R6 denormal as zero",32'h00000001, 32'h3F800000, 32'h00000000, 32'h00000000);
        directed("R6 flush tiny",      32'h00800000, 32'h3F000000, 32'h00000000, 32'h00000000);
        // R7: specials
        directed("R7 inf times zero",  32'h7F800000, 32'h00000000, 32'h3F800000, 32'h7FC00000);
        directed("R7 inf minus inf",   32'h7F800000, 32'h3F800000, 32'hFF800000, 32'h7FC00000);
        directed("R7 inf product",     32'hFF800000, 32'h3F800000, 32'h3F800000, 32'hFF800000);
        directed("R7 nan input",       32'h3F800000, 32'h3F800000, 32'h7FC12345, 32'h7FC00000);
        directed("R7 overflow",        32'h7F7FFFFF, 32'h40000000, 32'h00000000, 32'h7F800000);

        // R2: order codes with a=2, b=3, c=5
        a = {4{32'h40000000}}; b = {4{32'h40400000}}; c = {4{32'h40A00000}};
        apply(a, b, c, 2'd0, 3'd0, 1'b0); chk("R2 order0", result[31:0], 32'h41500000);
        apply(a, b, c, 2'd1, 3'd0, 1'b0); chk("R2 order1", result[63:32], 32'h41300000);
        apply(a, b, c, 2'd2, 3'd0, 1'b0); chk("R2 order2", result[95:64], 32'h41880000);
        apply(a, b, c, 2'd3, 3'd0, 1'b0); chk("R2 order3", result[127:96], 32'h41300000);
        // R3: sign variants, order 1 gives 2*3 and addend 5
        apply(a, b, c, 2'd1, 3'd1, 1'b0); chk("R3 op1", result[31:0], 32'h3F800000);
        apply(a, b, c, 2'd1, 3'd2, 1'b0); chk("R3 op2", result[31:0], 32'hBF800000);
        apply(a, b, c, 2'd1, 3'd3, 1'b0); chk("R3 op3", result[31:0], 32'hC1300000);
        apply(a, b, c, 2'd1, 3'd6, 1'b0); chk("R3 op6", result[31:0], 32'h41300000);
        apply(a, b, c, 2'd1, 3'd7, 1'b0); chk("R3 op7", result[31:0], 32'h41300000);
        // R4: alternating lanes with 1*1 +/- 1
        a = {4{32'h3F800000}};
        apply(a, a, a, 2'd1, 3'd4, 1'b0);
        for (int l = 0; l < 4; l++) chk("R4 op4", result[l*32 +: 32], (l % 2 == 0) ? 32'h0 : 32'h40000000);
        apply(a, a, a, 2'd1, 3'd5, 1'b0);
        for (int l = 0; l < 4; l++) chk("R4 op5", result[l*32 +: 32], (l % 2 == 1) ? 32'h0 : 32'h40000000);
        // R5: scalar pass-through
        a = {32'h11111111, 32'h22222222, 32'h33333333, 32'h40000000};
        apply(a, b, c, 2'd1, 3'd0, 1'b1);
        chk("R5 scalar lane0", result[31:0], 32'h41300000);
        for (int l = 1; l < 4; l++) chk("R5 scalar upper", result[l*32 +: 32], a[l*32 +: 32]);
        // R8: hold without strobe
        exp_v = result;
        @(negedge clk);
        src_a = ~src_a; src_b = ~src_b; op_sel = 3'd3;
        @(negedge clk);
        chk("R8 no valid", {31'd0, out_valid}, 32'd0);
        for (int l = 0; l < 4; l++) chk("R8 hold", result[l*32 +: 32], exp_v[l*32 +: 32]);

        // Random vectors for R1..R5
        for (int n = 0; n < 400; n++) begin
            logic [1:0] ord = 2'($urandom % 4);
            logic [2:0] op  = 3'($urandom % 8);
            logic       sc  = ($urandom % 4) == 0;
            for (int l = 0; l < 4; l++) begin
                int exx = 100 + int'($urandom % 55);
                int eyy = 100 + int'($urandom % 55);
                int ezz = exx + eyy - 127 + int'($urandom % 7) - 3;
                logic [31:0] x = {1'($urandom), 8'(exx), 23'($urandom)};
                logic [31:0] y = {1'($urandom), 8'(eyy), 23'($urandom)};
                logic [31:0] z = {1'($urandom), 8'(ezz), 23'($urandom)};
                bit neg = (op == 3'd2) || (op == 3'd3);
                bit sub = (op == 3'd1) || (op == 3'd3) ||
                          (op == 3'd4 && l % 2 == 0) || (op == 3'd5 && l % 2 == 1);
                case (ord)
                    2'd0:    begin a[l*32 +: 32] = x; c[l*32 +: 32] = y; b[l*32 +: 32] = z; end
                    2'd2:    begin b[l*32 +: 32] = x; c[l*32 +: 32] = y; a[l*32 +: 32] = z; end
                    default: begin b[l*32 +: 32] = x; a[l*32 +: 32] = y; c[l*32 +: 32] = z; end
                endcase
                exp_v[l*32 +: 32] = ref_fma(x, y, z, neg, sub);
            end
            for (int l = 1; l < 4; l++) if (sc) exp_v[l*32 +: 32] = a[l*32 +: 32];
            apply(a, b, c, ord, op, sc);
            chk("R8 valid", {31'd0, out_valid}, 32'd1);
            for (int l = 0; l < 4; l++) chk("R1 R2 R3 R4 R5 random", result[l*32 +: 32], exp_v[l*32 +: 32]);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule